// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds a small set of one-bit hardware semaphores that two independent agents, called left and right, use to reserve shared resources. The semaphores sit apart from any data storage. Each port reaches them through its own select, a semaphore index taken from the low address bits, a write strobe, a data bus and a registered read bus. Everything runs on one clock.

A port claims a semaphore by writing 0 to it. It frees the semaphore, or withdraws a claim it made earlier, by writing 1. If a port asks for a semaphore while the other port holds it, the claim is remembered and takes effect in the same cycle the holder lets go. A port reads 0 from a semaphore it holds and 1 from every other semaphore. The read value is copied to every bit of the read bus and stays in an output register until that port reads again.

Top module: `sem_bank`

## Requirements
- R1: After reset no semaphore has an owner and no claim is waiting, so every read on either port returns all ones.
- R2: A port accesses a semaphore only in a cycle where its select is low (active) and its memory enable is high (inactive). In any other cycle its write and read inputs have no effect.
- R3: The semaphore index is the low log2(NUM_SEM) address bits (bits 2:0 with eight semaphores). The higher address bits are ignored.
- R4: A write uses only data bit 0: 0 claims the semaphore and 1 releases it. All other data bits are ignored.
- R5: When a port writes 0 to a semaphore that has no owner, that port becomes the owner. It then reads 0 (all bits) and the other port reads all ones.
- R6: Only the owner can change who owns a semaphore. A write of 1 from the other port does not release it.
- R7: When the owner writes 1, the semaphore becomes free and both ports read all ones, unless a claim from the other port is waiting (see R8).
- R8: A port that writes 0 while the other port owns the semaphore is recorded as waiting. It becomes the owner in the same cycle the owner releases it.
- R9: A waiting port that writes 1 withdraws its claim. A later release by the owner then leaves the semaphore free.
- R10: When both ports write 0 to the same free semaphore in the same cycle, the left port wins and the right port's claim waits. This is the default, with LEFT_WINS=1.
- R11: A read access loads the read register one clock later with the reader's view replicated on all bits. Without a new read access by that port, its read register holds its value, even while the other port writes.
- R12: The two ports never both own the same semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory enable, active low; must be high for a semaphore access |
| l_addr | input | ADDR_W | Left address; only the low index bits are used |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_wdata | input | DATA_W | Left write data; bit 0 is used |
| l_rdata | output | DATA_W | Left registered read data |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory enable, active low; must be high for a semaphore access |
| r_addr | input | ADDR_W | Right address; only the low index bits are used |
| r_wr | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_wdata | input | DATA_W | Right write data; bit 0 is used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
The bench builds the block with its defaults: eight semaphores, a 12-bit address, a 16-bit data bus and left-wins priority. The 12-bit address lets it show that the nine upper address bits are ignored. The 16-bit bus lets it show that bit 0 alone decides a write and that reads fill all sixteen bits. With only eight semaphores, random traffic from both ports keeps hitting the same semaphore at once. That regularly produces same-cycle claims, hand-overs to a waiting port and withdrawn claims, on top of the directed cases.

// File: rtl/sem_pkg.sv
package sem_pkg;
   // Per-semaphore state: who owns it and who is waiting for it
   typedef struct packed {
      logic own_l;
      logic own_r;
      logic wait_l;
      logic wait_r;
   } sem_state_t;

   localparam sem_state_t SEM_IDLE = '{own_l: 1'b0, own_r: 1'b0, wait_l: 1'b0, wait_r: 1'b0};
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 16,
   localparam int IDX_W  = $clog2(NUM_SEM)
) (
   input  logic               sel_n,
   input  logic               ce_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SEM-1:0] wr_hit,
   output logic               wr_bit,
   output logic               rd_go,
   output logic [IDX_W-1:0]   idx
);
   logic active;

   // R2: semaphore access needs select low and memory enable high
   assign active = ~sel_n & ce_n;
   // R3: only the low index bits pick the semaphore
   assign idx    = addr[IDX_W-1:0];
   // R4: bit 0 alone carries the write value
   assign wr_bit = wdata[0];
   assign rd_go  = active & ~wr;

   always_comb begin
      wr_hit = '0;
      if (active && wr) wr_hit[idx] = 1'b1;
   end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_pkg::*;
#(
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_l,
   input  logic val_l,
   input  logic wr_r,
   input  logic val_r,
   output logic own_l,
   output logic own_r
);
   sem_state_t st, st_nxt;
   logic want_l, want_r, keep_l, keep_r, free_nxt;
   logic take_l, take_r;

   // A write sets or clears this port's desire; otherwise a waiting claim persists
   assign want_l = wr_l ? ~val_l : st.wait_l;
   assign want_r = wr_r ? ~val_r : st.wait_r;
   // An owner keeps the latch unless it writes 1
   assign keep_l = st.own_l & ~(wr_l & val_l);
   assign keep_r = st.own_r & ~(wr_r & val_r);
   assign free_nxt = ~keep_l & ~keep_r;

   generate
      if (LEFT_WINS) begin : g_left_first
         assign take_l = free_nxt & want_l;
         assign take_r = free_nxt & want_r & ~want_l;
      end else begin : g_right_first
         assign take_r = free_nxt & want_r;
         assign take_l = free_nxt & want_l & ~want_r;
      end
   endgenerate

   always_comb begin
      st_nxt.own_l  = keep_l | take_l;
      st_nxt.own_r  = keep_r | take_r;
      st_nxt.wait_l = want_l & ~st_nxt.own_l;
      st_nxt.wait_r = want_r & ~st_nxt.own_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SEM_IDLE;
      else        st <= st_nxt;
   end

   assign own_l = st.own_l;
   assign own_r = st.own_r;

   // R12: ownership is exclusive
   a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(own_l && own_r));
   // R5: a lone claim of a free latch wins
   a_r5_claim_left: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l && !own_r && wr_l && !val_l && !(wr_r && !val_r)) |=> own_l);
   a_r5_claim_right: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l && !own_r && wr_r && !val_r && !(wr_l && !val_l)) |=> own_r);
   // R6: the owner holds unless it writes 1
   a_r6_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l && !(wr_l && val_l)) |=> own_l);
   a_r6_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
      (own_r && !(wr_r && val_r)) |=> own_r);
   // R8: a waiting claim takes over on release
   a_r8_handover_r: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l && wr_l && val_l && st.wait_r && !wr_r) |=> own_r);
   a_r8_handover_l: assert property (@(posedge clk) disable iff (!rst_n)
      (own_r && wr_r && val_r && st.wait_l && !wr_l) |=> own_l);
endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic              view,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '1;
      else if (rd_go) rdata <= {DATA_W{view}};
   end

   // R11: the register only moves on this port's read
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> $stable(rdata));
   // R11: every bit carries the same value
   a_r11_replicated: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(rdata) == 0) || ($countones(rdata) == DATA_W));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_SEM   = 8,
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 16,
   parameter bit LEFT_WINS = 1'b1,
   localparam int IDX_W    = $clog2(NUM_SEM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel_n,
   input  logic              l_ce_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_wr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sel_n,
   input  logic              r_ce_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_wr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   generate
      if (NUM_SEM < 2 || (1 << IDX_W) != NUM_SEM) begin : g_bad_num
         $error("sem_bank: NUM_SEM must be a power of two of at least 2");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("sem_bank: ADDR_W narrower than the semaphore index");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("sem_bank: DATA_W must be positive");
      end
   endgenerate

   logic [NUM_SEM-1:0] l_hit, r_hit, own_l, own_r;
   logic               l_bit, r_bit, l_rd, r_rd;
   logic [IDX_W-1:0]   l_idx, r_idx;

   sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
      .sel_n(l_sel_n), .ce_n(l_ce_n), .addr(l_addr), .wr(l_wr), .wdata(l_wdata),
      .wr_hit(l_hit), .wr_bit(l_bit), .rd_go(l_rd), .idx(l_idx));

   sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
      .sel_n(r_sel_n), .ce_n(r_ce_n), .addr(r_addr), .wr(r_wr), .wdata(r_wdata),
      .wr_hit(r_hit), .wr_bit(r_bit), .rd_go(r_rd), .idx(r_idx));

   generate
      for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
         sem_cell #(.LEFT_WINS(LEFT_WINS)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .wr_l(l_hit[g]), .val_l(l_bit),
            .wr_r(r_hit[g]), .val_r(r_bit),
            .own_l(own_l[g]), .own_r(own_r[g]));
      end
   endgenerate

   // Each port sees 0 only for a latch it holds
   sem_rd_reg #(.DATA_W(DATA_W)) u_rd_l (
      .clk(clk), .rst_n(rst_n), .rd_go(l_rd), .view(~own_l[l_idx]), .rdata(l_rdata));
   sem_rd_reg #(.DATA_W(DATA_W)) u_rd_r (
      .clk(clk), .rst_n(rst_n), .rd_go(r_rd), .view(~own_r[r_idx]), .rdata(r_rdata));

   // R2: no write reaches a latch without a proper select
   a_r2_gate_left: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel_n || !l_ce_n) |-> (l_hit == '0));
   a_r2_gate_right: assert property (@(posedge clk) disable iff (!rst_n)
      (r_sel_n || !r_ce_n) |-> (r_hit == '0));
   // R2: a read without a proper select leaves the read register alone
   a_r2_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel_n || !l_ce_n) |=> $stable(l_rdata));
endmodule

// File: tb/test_sem_bank.sv
`timescale 1ns/1ps
module test_sem_bank;
   localparam int NUM = 8;
   localparam int AW  = 12;
   localparam int DW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sel_n = 1'b1, l_ce_n = 1'b1, l_wr = 1'b0;
   logic r_sel_n = 1'b1, r_ce_n = 1'b1, r_wr = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // Bench model state
   bit m_own_l[NUM], m_own_r[NUM], m_wait_l[NUM], m_wait_r[NUM];
   logic [DW-1:0] exp_l = '1, exp_r = '1;

   always #2.5 clk = ~clk;

   sem_bank i_sem_bank (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_addr(l_addr), .l_wr(l_wr),
      .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_addr(r_addr), .r_wr(r_wr),
      .r_wdata(r_wdata), .r_rdata(r_rdata));

   task automatic check(string tag, string side, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s port %s: got %h expected %h", tag, side, act, exp);
      end
   endtask

   // Model one clock of traffic according to the requirements
   task automatic model_step();
      bit la, ra, lw, rw;
      la = !l_sel_n && l_ce_n;
      ra = !r_sel_n && r_ce_n;
      if (la && !l_wr) exp_l = {DW{!m_own_l[l_addr[2:0]]}};
      if (ra && !r_wr) exp_r = {DW{!m_own_r[r_addr[2:0]]}};
      for (int i = 0; i < NUM; i++) begin
         lw = la && l_wr && (l_addr[2:0] == i);
         rw = ra && r_wr && (r_addr[2:0] == i);
         if (lw) m_wait_l[i] = !l_wdata[0];
         if (rw) m_wait_r[i] = !r_wdata[0];
         if (m_own_l[i] && lw && l_wdata[0]) m_own_l[i] = 0;
         if (m_own_r[i] && rw && r_wdata[0]) m_own_r[i] = 0;
         if (!m_own_l[i] && !m_own_r[i]) begin
            if (m_wait_l[i])      m_own_l[i] = 1;
            else if (m_wait_r[i]) m_own_r[i] = 1;
         end
         if (m_own_l[i]) m_wait_l[i] = 0;
         if (m_own_r[i]) m_wait_r[i] = 0;
      end
   endtask

   task automatic op(string tag,
                     logic lsn, logic lcn, logic [AW-1:0] la, logic lw, logic [DW-1:0] ld,
                     logic rsn, logic rcn, logic [AW-1:0] ra, logic rw, logic [DW-1:0] rd);
      @(negedge clk);
      l_sel_n = lsn; l_ce_n = lcn; l_addr = la; l_wr = lw; l_wdata = ld;
      r_sel_n = rsn; r_ce_n = rcn; r_addr = ra; r_wr = rw; r_wdata = rd;
      model_step();
      @(posedge clk);
      #1;
      check(tag, "L", l_rdata, exp_l);
      check(tag, "R", r_rdata, exp_r);
   endtask

   // Shorthands: idle, write, read on one side with the other idle
   task automatic lwr(string tag, logic [AW-1:0] a, logic [DW-1:0] d);
      op(tag, 0, 1, a, 1, d, 1, 1, '0, 0, '0);
   endtask
   task automatic rwr(string tag, logic [AW-1:0] a, logic [DW-1:0] d);
      op(tag, 1, 1, '0, 0, '0, 0, 1, a, 1, d);
   endtask
   task automatic both_rd(string tag, logic [AW-1:0] la, logic [AW-1:0] ra);
      op(tag, 0, 1, la, 0, '0, 0, 1, ra, 0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < NUM; i++) begin
         m_own_l[i] = 0; m_own_r[i] = 0; m_wait_l[i] = 0; m_wait_r[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state of the read registers
      check("R1", "L", l_rdata, 16'hFFFF);
      check("R1", "R", r_rdata, 16'hFFFF);
      @(negedge clk) rst_n = 1'b1;

      // R1: every semaphore free after reset
      both_rd("R1", 12'h000, 12'h007);
      check("R1", "L", l_rdata, 16'hFFFF);
      check("R1", "R", r_rdata, 16'hFFFF);

      // R5: left claims semaphore 3
      lwr("R5", 12'h003, 16'h0000);
      both_rd("R5", 12'h003, 12'h003);
      check("R5", "L", l_rdata, 16'h0000);
      check("R5", "R", r_rdata, 16'hFFFF);

      // R6: right cannot release what left holds
      rwr("R6", 12'h003, 16'h0001);
      both_rd("R6", 12'h003, 12'h003);
      check("R6", "L", l_rdata, 16'h0000);

      // R2: right claim with memory enable active is ignored; R7: left release frees
      op("R2", 1, 1, '0, 0, '0, 0, 0, 12'h003, 1, 16'h0000);
      lwr("R7", 12'h003, 16'h0001);
      both_rd("R7", 12'h003, 12'h003);
      check("R7", "L", l_rdata, 16'hFFFF);
      check("R2", "R", r_rdata, 16'hFFFF);

      // R3: upper address bits ignored
      lwr("R3", 12'hA05, 16'h0000);
      both_rd("R3", 12'h305, 12'h005);
      check("R3", "L", l_rdata, 16'h0000);
      check("R3", "R", r_rdata, 16'hFFFF);

      // R4: only bit 0 of the write data counts
      rwr("R4", 12'h006, 16'hFFFE);
      lwr("R4", 12'h006, 16'h0001);
      both_rd("R4", 12'h006, 12'h006);
      check("R4", "R", r_rdata, 16'h0000);
      check("R4", "L", l_rdata, 16'hFFFF);

      // R8: left waits on semaphore 6, gets it on right release
      lwr("R8", 12'h006, 16'h0000);
      both_rd("R8", 12'h006, 12'h006);
      check("R8", "L", l_rdata, 16'hFFFF);
      rwr("R8", 12'h006, 16'h0001);
      both_rd("R8", 12'h006, 12'h006);
      check("R8", "L", l_rdata, 16'h0000);
      check("R8", "R", r_rdata, 16'hFFFF);

      // R9: right claims then withdraws; left release leaves it free
      rwr("R9", 12'h006, 16'h0000);
      rwr("R9", 12'h006, 16'h0001);
      lwr("R9", 12'h006, 16'h0001);
      both_rd("R9", 12'h006, 12'h006);
      check("R9", "L", l_rdata, 16'hFFFF);
      check("R9", "R", r_rdata, 16'hFFFF);

      // R10: same-cycle claims on semaphore 1, left first
      op("R10", 0, 1, 12'h001, 1, 16'h0000, 0, 1, 12'h001, 1, 16'h0000);
      both_rd("R10", 12'h001, 12'h001);
      check("R10", "L", l_rdata, 16'h0000);
      check("R10", "R", r_rdata, 16'hFFFF);
      lwr("R10", 12'h001, 16'h0001);
      both_rd("R10", 12'h001, 12'h001);
      check("R10", "R", r_rdata, 16'h0000);

      // R11: right read value held while left writes and right stays idle
      rwr("R11", 12'h001, 16'h0001);
      lwr("R11", 12'h001, 16'h0000);
      check("R11", "R", r_rdata, 16'h0000);
      op("R11", 1, 1, '0, 0, '0, 0, 0, 12'h001, 0, '0);
      check("R11", "R", r_rdata, 16'h0000);

      // R12: random traffic from both ports against the model
      for (int n = 0; n < 4000; n++) begin
         op("R12",
            ($urandom % 5) == 0, ($urandom % 6) != 0, AW'($urandom), $urandom % 2, DW'($urandom),
            ($urandom % 5) == 0, ($urandom % 6) != 0, AW'($urandom), $urandom % 2, DW'($urandom));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule